// File: doc/BRIEF.md
# Late-Window Memory Write Strobe Generator

This block turns a fast oscillator into the CPU clock and into a memory write clock that is active only in a short, late slice of each CPU cycle. The oscillator is represented by a sampling clock plus an `osc_tick` enable. Each tick is one oscillator half-period. A chain of toggle stages divides the oscillator by four, so one CPU cycle spans eight ticks. The write clock is high only in the slice from three quarters to seven eighths of the cycle, and only when the memory write enable is high. The address therefore settles well before the write begins, and the CPU clock cannot move while the write is in progress.

A stop request parks the divider. It forces every toggle stage to its set value and holds the CPU clock low, so the divider always restarts from the same phase. While the divider is parked, a single-step pulse produces one oscillator period of CPU clock, followed by one oscillator period of write clock.

The divider control has two states. `CY_PARK` moves to `CY_RUN` when the stop request is low and the step sequencer is idle. `CY_RUN` returns to `CY_PARK` as soon as a stop request is seen. The step sequencer has three states:
- `MS_IDLE` moves to `MS_CLK` when a step pulse arrives while the divider is parked and the stop request is held.
- `MS_CLK` moves to `MS_WR` after two ticks.
- `MS_WR` returns to `MS_IDLE` after two more ticks.

Top module: `memwr_strobe`

## Requirements
- R1: While `rst` is high, `cpu_clk` and `wr_clk` are both low. After reset the divider is parked, with every toggle stage set.
- R2: While running with `osc_tick` high every clock, `cpu_clk` has a period of 8 ticks. Counting from a rising edge as phase 0, it is high in phases 0 to 3 and low in phases 4 to 7.
- R3: With `mem_we` high, `wr_clk` is high in phase 6 only (three quarters to seven eighths of the cycle), for one tick per cycle.
- R4: While `mem_we` is low, `wr_clk` stays low in every mode.
- R5: From the clock after `stop_req` is seen high, with no step pending, `cpu_clk` and `wr_clk` stay low.
- R6: After `stop_req` falls, the divider enters `CY_RUN` at the next clock. `cpu_clk` then rises on the first tick after that, at phase 0.
- R7: When parked with `stop_req` high, a `step_req` pulse makes `cpu_clk` high from the next clock for two ticks (one oscillator period).
- R8: After a step, `wr_clk` (if `mem_we` is high) rises two ticks after `cpu_clk` rose, stays high for two ticks, and then falls.
- R9: `step_req` is ignored while running and while a step sequence is in progress.
- R10: If `stop_req` falls during a step sequence, the divider stays parked until the sequence has finished.
- R11: `wr_clk` and `cpu_clk` are never high together, and `cpu_clk` has no rising edge during, or in the clock right after, a write pulse. A memory address updated on `cpu_clk` is therefore constant for the whole pulse.
- R12: While running, a clock without `osc_tick` leaves `cpu_clk` and `wr_clk` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One oscillator half-period has elapsed |
| mem_we | input | 1 | Memory write enable from the CPU |
| stop_req | input | 1 | Stop request: parks the divider |
| step_req | input | 1 | Manual single-step pulse |
| cpu_clk | output | 1 | Divided CPU clock |
| wr_clk | output | 1 | Gated memory write clock |

## Verification
Several rules are checked by the assertions on every cycle:
- the write clock never overlaps the CPU clock, and no CPU clock edge follows a write;
- the write-enable gating;
- quiet outputs after a stop;
- holding when no tick arrives;
- the parked divider waiting for the step sequencer.

Other behaviour can only be shown by the bench's scenarios, because it depends on exact tick counts:
- the eight-phase clock shape and the exact write slice;
- the phase at which the clock restarts after a stop;
- the step clock and step write timings;
- that extra step pulses have no effect.

A bench-side address register, clocked by the CPU clock, is watched across every write pulse.

// File: rtl/memwr_strobe_pkg.sv
package memwr_strobe_pkg;

    typedef enum logic {
        CY_PARK = 1'b0,
        CY_RUN  = 1'b1
    } cyc_state_e;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_CLK  = 2'd1,
        MS_WR   = 2'd2
    } step_state_e;

endpackage

// File: rtl/memwr_toggle.sv
// One divider stage: flips on tog_i, forced to 1 by set_i or reset.
module memwr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic tog_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst || set_i) begin
            q_o <= 1'b1;
        end else if (tog_i) begin
            q_o <= ~q_o;
        end
    end
endmodule

// File: rtl/memwr_cycle.sv
// Free-running divider: oscillator level stage plus DIV_STAGES toggle stages.
module memwr_cycle
    import memwr_strobe_pkg::*;
#(
    parameter int DIV_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic stop_req,
    input  logic man_idle,
    output logic run_clk,
    output logic run_win,
    output logic parked
);
    localparam int STAGES = DIV_STAGES + 1;
    localparam int PHASES = 1 << STAGES;
    localparam int WIN_LO = (PHASES * 6) / 8;
    localparam int WIN_HI = (PHASES * 7) / 8;
    localparam logic [STAGES-1:0] WIN_LO_V = STAGES'(WIN_LO);
    localparam logic [STAGES-1:0] WIN_HI_V = STAGES'(WIN_HI);

    cyc_state_e st_q, st_d;
    logic [STAGES-1:0] q;
    logic [STAGES-1:0] carry;
    logic force_set;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= CY_PARK;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CY_PARK: if (!stop_req && man_idle) st_d = CY_RUN;
            CY_RUN:  if (stop_req)              st_d = CY_PARK;
            default: st_d = CY_PARK;
        endcase
    end

    assign force_set = (st_q == CY_PARK) || stop_req;
    assign carry[0]  = osc_tick && (st_q == CY_RUN);

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_carry
            assign carry[g] = carry[g-1] & q[g-1];
        end
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            memwr_toggle u_tog (
                .clk   (clk),
                .rst   (rst),
                .set_i (force_set),
                .tog_i (carry[s]),
                .q_o   (q[s])
            );
        end
    endgenerate

    // outputs
    always_comb begin
        parked  = (st_q == CY_PARK);
        run_clk = (st_q == CY_RUN) && !q[STAGES-1];
        run_win = (st_q == CY_RUN) && (q >= WIN_LO_V) && (q < WIN_HI_V);
    end
endmodule

// File: rtl/memwr_step.sv
// Single-step sequencer: one oscillator period of clock, then one of write.
module memwr_step
    import memwr_strobe_pkg::*;
#(
    parameter int TICKS_PER_OSC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic step_req,
    input  logic stop_req,
    input  logic parked,
    output logic man_clk,
    output logic man_wr,
    output logic man_idle
);
    localparam int SW = (TICKS_PER_OSC > 1) ? $clog2(TICKS_PER_OSC) : 1;
    localparam logic [SW-1:0] LAST = SW'(TICKS_PER_OSC - 1);

    step_state_e st_q, st_d;
    logic [SW-1:0] sub_q, sub_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= MS_IDLE;
            sub_q <= '0;
        end else begin
            st_q  <= st_d;
            sub_q <= sub_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        sub_d = sub_q;
        unique case (st_q)
            MS_IDLE: begin
                if (step_req && parked && stop_req) begin
                    st_d  = MS_CLK;
                    sub_d = '0;
                end
            end
            MS_CLK: begin
                if (osc_tick) begin
                    if (sub_q == LAST) begin
                        st_d  = MS_WR;
                        sub_d = '0;
                    end else begin
                        sub_d = sub_q + SW'(1);
                    end
                end
            end
            MS_WR: begin
                if (osc_tick) begin
                    if (sub_q == LAST) begin
                        st_d  = MS_IDLE;
                        sub_d = '0;
                    end else begin
                        sub_d = sub_q + SW'(1);
                    end
                end
            end
            default: begin
                st_d  = MS_IDLE;
                sub_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        man_idle = (st_q == MS_IDLE);
        man_clk  = (st_q == MS_CLK);
        man_wr   = (st_q == MS_WR);
    end
endmodule

// File: rtl/memwr_strobe.sv
module memwr_strobe #(
    parameter int DIV_STAGES    = 2,
    parameter int TICKS_PER_OSC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic mem_we,
    input  logic stop_req,
    input  logic step_req,
    output logic cpu_clk,
    output logic wr_clk
);
    logic run_clk, run_win, parked;
    logic man_clk, man_wr, man_idle;

    memwr_cycle #(.DIV_STAGES(DIV_STAGES)) u_cycle (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .stop_req (stop_req),
        .man_idle (man_idle),
        .run_clk  (run_clk),
        .run_win  (run_win),
        .parked   (parked)
    );

    memwr_step #(.TICKS_PER_OSC(TICKS_PER_OSC)) u_step (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .step_req (step_req),
        .stop_req (stop_req),
        .parked   (parked),
        .man_clk  (man_clk),
        .man_wr   (man_wr),
        .man_idle (man_idle)
    );

    assign cpu_clk = run_clk | man_clk;
    assign wr_clk  = mem_we & (run_win | man_wr);
endmodule

// File: rtl/memwr_strobe_chk.sv
module memwr_strobe_chk (
    input logic clk,
    input logic rst,
    input logic osc_tick,
    input logic mem_we,
    input logic stop_req,
    input logic step_req,
    input logic cpu_clk,
    input logic wr_clk,
    input logic parked,
    input logic man_idle
);
    // R11
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clk |-> !cpu_clk);

    // R11
    no_edge_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clk |=> !$rose(cpu_clk));

    // R4
    we_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> !wr_clk);

    // R5
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !step_req && man_idle) |=> (!cpu_clk && !wr_clk));

    // R12
    tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!osc_tick && !parked && !stop_req) |=> $stable(cpu_clk));

    // R10
    park_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (parked && !man_idle) |=> parked);
endmodule

bind memwr_strobe memwr_strobe_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .osc_tick (osc_tick),
    .mem_we   (mem_we),
    .stop_req (stop_req),
    .step_req (step_req),
    .cpu_clk  (cpu_clk),
    .wr_clk   (wr_clk),
    .parked   (parked),
    .man_idle (man_idle)
);

// File: tb/sim_memwr_strobe.sv
module sim_memwr_strobe;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b1;
    logic mem_we = 1'b1;
    logic stop_req = 1'b0;
    logic step_req = 1'b0;
    logic cpu_clk, wr_clk;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    memwr_strobe u0 (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .mem_we   (mem_we),
        .stop_req (stop_req),
        .step_req (step_req),
        .cpu_clk  (cpu_clk),
        .wr_clk   (wr_clk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // R11: address register clocked by cpu_clk must not move during a write pulse
    int addr = 0;
    int addr_hold = 0;
    bit wr_prev = 1'b0;
    always @(posedge cpu_clk) addr = addr + 1;
    always @(negedge clk) begin
        if (!rst && wr_clk) begin
            if (!wr_prev) addr_hold = addr;
            else chk(addr == addr_hold, "R11 addr stable", addr, addr_hold);
            chk(cpu_clk == 1'b0, "R11 no overlap", cpu_clk, 0);
        end
        wr_prev = wr_clk;
    end

    task automatic wait_rise();
        bit prev = cpu_clk;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (cpu_clk && !prev) return;
            prev = cpu_clk;
        end
        chk(1'b0, "R2 no rising cpu_clk", 0, 1);
    endtask

    // current sample is phase 0; records 8 phases
    task automatic capture(output logic [7:0] cv, output logic [7:0] wv);
        cv[0] = cpu_clk;
        wv[0] = wr_clk;
        for (int p = 1; p < 8; p++) begin
            @(negedge clk);
            step_req = 1'b0;
            cv[p] = cpu_clk;
            wv[p] = wr_clk;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cpu_clk == 1'b0, "R1 cpu_clk in reset", cpu_clk, 0);
        chk(wr_clk == 1'b0, "R1 wr_clk in reset", wr_clk, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_clk == 1'b0, "R1 parked stage set", cpu_clk, 0);
        @(negedge clk);
        chk(cpu_clk == 1'b1, "R6 first rise after reset", cpu_clk, 1);
    endtask

    task automatic t_run_pattern();
        logic [7:0] cv, wv;
        mem_we = 1'b1;
        wait_rise();
        capture(cv, wv);
        chk(cv == 8'b0000_1111, "R2 clock shape", cv, 8'b0000_1111);
        chk(wv == 8'b0100_0000, "R3 write slice", wv, 8'b0100_0000);
        @(negedge clk);
        chk(cpu_clk == 1'b1, "R2 period 8", cpu_clk, 1);
    endtask

    task automatic t_no_we();
        logic [7:0] cv, wv;
        mem_we = 1'b0;
        wait_rise();
        capture(cv, wv);
        chk(cv == 8'b0000_1111, "R4 clock unchanged", cv, 8'b0000_1111);
        chk(wv == 8'b0, "R4 no write without we", wv, 0);
        mem_we = 1'b1;
    endtask

    task automatic t_stop_resume();
        logic [7:0] cv, wv;
        mem_we = 1'b1;
        wait_rise();
        stop_req = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(cpu_clk == 1'b0 && wr_clk == 1'b0, "R5 quiet when stopped",
                {cpu_clk, wr_clk}, 0);
        end
        stop_req = 1'b0;
        @(negedge clk);
        chk(cpu_clk == 1'b0, "R6 enter run, not yet high", cpu_clk, 0);
        @(negedge clk);
        chk(cpu_clk == 1'b1, "R6 rise on first tick", cpu_clk, 1);
        capture(cv, wv);
        chk(cv == 8'b0000_1111, "R6 resume clock shape", cv, 8'b0000_1111);
        chk(wv == 8'b0100_0000, "R6 resume write slice", wv, 8'b0100_0000);
    endtask

    task automatic t_manual(input bit we, input bit extra_step);
        logic [4:0] cv, wv;
        logic [4:0] wexp;
        mem_we = we;
        stop_req = 1'b1;
        repeat (3) @(negedge clk);
        step_req = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (!(extra_step && i == 0)) step_req = 1'b0;
            cv[i] = cpu_clk;
            wv[i] = wr_clk;
        end
        wexp = we ? 5'b01100 : 5'b00000;
        chk(cv == 5'b00011, extra_step ? "R9 busy step ignored clk" : "R7 step clock",
            cv, 5'b00011);
        chk(wv == wexp, we ? (extra_step ? "R9 busy step ignored wr" : "R8 step write")
                           : "R4 step without we", wv, wexp);
        repeat (3) @(negedge clk);
        chk(cpu_clk == 1'b0 && wr_clk == 1'b0, "R7 step done", {cpu_clk, wr_clk}, 0);
        stop_req = 1'b0;
        mem_we = 1'b1;
    endtask

    task automatic t_step_while_run();
        logic [7:0] cv, wv;
        mem_we = 1'b1;
        wait_rise();
        step_req = 1'b1;
        capture(cv, wv);
        chk(cv == 8'b0000_1111, "R9 run step clk", cv, 8'b0000_1111);
        chk(wv == 8'b0100_0000, "R9 run step wr", wv, 8'b0100_0000);
    endtask

    task automatic t_release_in_step();
        logic [6:0] cv, wv;
        mem_we = 1'b1;
        stop_req = 1'b1;
        repeat (3) @(negedge clk);
        step_req = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            step_req = 1'b0;
            stop_req = 1'b0;
            cv[i] = cpu_clk;
            wv[i] = wr_clk;
        end
        chk(cv == 7'b1000011, "R10 run waits for step", cv, 7'b1000011);
        chk(wv == 7'b0001100, "R10 step write kept", wv, 7'b0001100);
    endtask

    task automatic t_tick_hold();
        mem_we = 1'b1;
        wait_rise();
        repeat (6) @(negedge clk);
        chk(wr_clk == 1'b1, "R3 at phase 6", wr_clk, 1);
        osc_tick = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cpu_clk == 1'b0 && wr_clk == 1'b1, "R12 hold without tick",
                {cpu_clk, wr_clk}, 1);
        end
        osc_tick = 1'b1;
        @(negedge clk);
        chk(wr_clk == 1'b0 && cpu_clk == 1'b0, "R12 resume at phase 7",
            {cpu_clk, wr_clk}, 0);
        @(negedge clk);
        chk(cpu_clk == 1'b1, "R12 next cycle", cpu_clk, 1);
    endtask

    initial begin
        t_reset();
        t_run_pattern();
        t_no_we();
        t_stop_resume();
        t_manual(1'b1, 1'b0);
        t_manual(1'b0, 1'b0);
        t_manual(1'b1, 1'b1);
        t_step_while_run();
        t_release_in_step();
        t_tick_hold();
        t_run_pattern();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
            $finish;
        end
    end
endmodule